// File: doc/BRIEF.md
# Receive FIFO with Configurable Interrupts

This block buffers received characters in a 128-word first-in first-out store. The receiver pushes words through a write strobe and the host pulls them through a read strobe, with read data coming back one clock later. The block also reports the fill level and raises three sticky interrupt flags: a threshold flag, an empty flag and an overrun flag.

The threshold is a 4-bit setting scaled by 8 into an entry count. The threshold flag fires when the fill level moves across that count: upward by default, or downward when the trigger-invert control is set. The empty flag fires by default when the store drains to empty. With the empty-invert control set, it fires instead when a word lands in an empty store. Flags fire only when the fill level moves. Each flag stays set until the host acknowledges it.

A configuration word, loaded by a strobe, holds the threshold, both invert controls and a clear control. While the clear control is set, the store stays empty. A software reset input has the same effect as the hardware reset: contents, flags and configuration all return to zero.

Top module: `rx_fifo_irq`

## Requirements
- R1: The store holds exactly 128 words: after 128 accepted writes `level` reads 128 and `full` is high.
- R2: Words are read in write order. An accepted read (`rd_en` with the store not empty) presents the word on `rd_data` with `rd_valid` high on the following cycle, and `level` drops by one.
- R3: A write while `full` is high is dropped. `level` and the stored words stay unchanged and `irq_ovr` sets.
- R4: A read while the store is empty has no effect: `rd_valid` stays low and `level` stays 0.
- R5: The threshold count is `cfg_trig_lvl` times 8. With `cfg_trig_inv` = 0, `irq_trig` sets when `level` moves from at most the threshold to above it.
- R6: With `cfg_trig_inv` = 1, `irq_trig` sets when `level` moves from at least the threshold to below it, and not when `level` rises.
- R7: With `cfg_empty_inv` = 0, `irq_empty` sets when `level` moves from nonzero to 0 and does not set on a write into an empty store.
- R8: With `cfg_empty_inv` = 1, `irq_empty` sets when a word is written into an empty store.
- R9: All flags are sticky until `irq_ack` is pulsed. A flag event in the same cycle as `irq_ack` leaves the flag set.
- R10: While the loaded clear control (`cfg_fifo_clr` = 1) is in effect, `level` is 0 one cycle later, and writes and reads are ignored. Normal operation resumes once it is loaded back to 0.
- R11: A pulse on `sw_rst` empties the store, clears all flags and returns every configuration field to 0.
- R12: The configuration inputs take effect only in a cycle with `cfg_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Software reset, same effect as `rst` |
| cfg_we | input | 1 | Loads the configuration fields below |
| cfg_trig_lvl | input | 4 | Threshold in units of 8 entries |
| cfg_trig_inv | input | 1 | Trigger on downward crossing |
| cfg_empty_inv | input | 1 | Empty flag on write into empty store |
| cfg_fifo_clr | input | 1 | Hold the store empty |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Received word |
| rd_en | input | 1 | Read strobe from the host |
| rd_data | output | 8 | Word read, valid with `rd_valid` |
| rd_valid | output | 1 | Read data present this cycle |
| level | output | 8 | Number of stored words |
| full | output | 1 | Store holds 128 words |
| empty | output | 1 | Store holds no words |
| irq_ack | input | 1 | Clears all sticky flags |
| irq_trig | output | 1 | Threshold crossing flag |
| irq_empty | output | 1 | Empty-related flag |
| irq_ovr | output | 1 | Overrun flag |

## Verification
On every cycle, the assertions check the level bound, that a dropped write on a full store leaves the level at 128, that an empty read cannot move the level, that the clear control and software reset empty the store, that flags stay set without an acknowledge, and that an accepted read produces `rd_valid`. The word order, the threshold scaling, the direction of each crossing under both invert settings, the meaning of the empty flag, and the gating of configuration by `cfg_we` can only be shown by the bench scenarios, which compare data and flags against values worked out from the requirements.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int TRIG_W = 4;

  typedef struct packed {
    logic              fifo_clr;
    logic              empty_inv;
    logic              trig_inv;
    logic [TRIG_W-1:0] trig_lvl;
  } rxf_cfg_t;
endpackage

// File: rtl/rx_fifo_mem.sv
module rx_fifo_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end

  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid); // R2
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          ovr_evt,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          full,
  output logic          empty
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (count == CW'(DEPTH));
    empty   = (count == '0);
    wr_ok   = wr_en && !full && !clr;
    rd_ok   = rd_en && !empty && !clr;
    ovr_evt = wr_en && full && !clr;
    if (clr)                count_nxt = '0;
    else if (wr_ok && !rd_ok) count_nxt = count + 1'b1;
    else if (rd_ok && !wr_ok) count_nxt = count - 1'b1;
    else                    count_nxt = count;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      count <= count_nxt;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !clr) |=> count == CW'(DEPTH)); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en) |=> count == '0); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0); // R10
endmodule

// File: rtl/rx_fifo_irq_gen.sv
module rx_fifo_irq_gen
  import rx_fifo_pkg::*;
#(
  parameter int CW        = 8,
  parameter int TRIG_SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  rxf_cfg_t      cfg,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] count_nxt,
  input  logic          ovr_evt,
  input  logic          ack,
  output logic          irq_trig,
  output logic          irq_empty,
  output logic          irq_ovr
);
  logic [CW-1:0] thresh;
  logic          trig_evt, empty_evt;

  always_comb begin
    thresh = CW'(cfg.trig_lvl) << TRIG_SHIFT;
    if (cfg.fifo_clr)
      trig_evt = 1'b0;
    else if (cfg.trig_inv)
      trig_evt = (count >= thresh) && (count_nxt < thresh);
    else
      trig_evt = (count <= thresh) && (count_nxt > thresh);
    if (cfg.fifo_clr)
      empty_evt = 1'b0;
    else if (cfg.empty_inv)
      empty_evt = (count == '0) && (count_nxt != '0);
    else
      empty_evt = (count != '0) && (count_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_trig  <= 1'b0;
      irq_empty <= 1'b0;
      irq_ovr   <= 1'b0;
    end else begin
      irq_trig  <= (irq_trig  && !ack) || trig_evt;
      irq_empty <= (irq_empty && !ack) || empty_evt;
      irq_ovr   <= (irq_ovr   && !ack) || ovr_evt;
    end
  end

  AST_STICKY_TRIG: assert property (@(posedge clk) disable iff (rst)
    (irq_trig && !ack) |=> irq_trig); // R9
  AST_STICKY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (irq_empty && !ack) |=> irq_empty); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> irq_ovr); // R3
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
  import rx_fifo_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DEPTH      = 128,
  parameter int TRIG_SHIFT = 3,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              cfg_we,
  input  logic [TRIG_W-1:0] cfg_trig_lvl,
  input  logic              cfg_trig_inv,
  input  logic              cfg_empty_inv,
  input  logic              cfg_fifo_clr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic [CW-1:0]     level,
  output logic              full,
  output logic              empty,
  input  logic              irq_ack,
  output logic              irq_trig,
  output logic              irq_empty,
  output logic              irq_ovr
);
  logic          any_rst;
  rxf_cfg_t      cfg;
  logic          wr_ok, rd_ok, ovr_evt;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_nxt;

  assign any_rst = rst || sw_rst;

  always_ff @(posedge clk) begin
    if (any_rst)     cfg <= '0;
    else if (cfg_we) cfg <= '{fifo_clr: cfg_fifo_clr, empty_inv: cfg_empty_inv,
                              trig_inv: cfg_trig_inv, trig_lvl: cfg_trig_lvl};
  end

  rx_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst(any_rst), .clr(cfg.fifo_clr),
    .wr_en(wr_en), .rd_en(rd_en),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .ovr_evt(ovr_evt),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(level), .count_nxt(count_nxt),
    .full(full), .empty(empty)
  );

  rx_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) i_mem (
    .clk(clk), .rst(any_rst),
    .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
    .re(rd_ok), .raddr(rd_ptr),
    .rdata(rd_data), .rvalid(rd_valid)
  );

  rx_fifo_irq_gen #(.CW(CW), .TRIG_SHIFT(TRIG_SHIFT)) i_irq (
    .clk(clk), .rst(any_rst), .cfg(cfg),
    .count(level), .count_nxt(count_nxt), .ovr_evt(ovr_evt),
    .ack(irq_ack),
    .irq_trig(irq_trig), .irq_empty(irq_empty), .irq_ovr(irq_ovr)
  );

  AST_SW_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (level == '0) && !irq_trig && !irq_empty && !irq_ovr); // R11
endmodule

// File: tb/test_rx_fifo_irq.sv
module test_rx_fifo_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, sw_rst, cfg_we, cfg_trig_inv, cfg_empty_inv, cfg_fifo_clr;
  logic [3:0] cfg_trig_lvl;
  logic       wr_en, rd_en, irq_ack;
  logic [7:0] wr_data, rd_data, level;
  logic       rd_valid, full, empty, irq_trig, irq_empty, irq_ovr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_irq i_rx_fifo_irq (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .cfg_we(cfg_we),
    .cfg_trig_lvl(cfg_trig_lvl), .cfg_trig_inv(cfg_trig_inv),
    .cfg_empty_inv(cfg_empty_inv), .cfg_fifo_clr(cfg_fifo_clr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .level(level),
    .full(full), .empty(empty), .irq_ack(irq_ack),
    .irq_trig(irq_trig), .irq_empty(irq_empty), .irq_ovr(irq_ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_load(input logic [3:0] lvl, input logic tinv, input logic einv, input logic clr);
    cfg_trig_lvl = lvl; cfg_trig_inv = tinv; cfg_empty_inv = einv; cfg_fifo_clr = clr;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d, output logic v);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk(level == 0, "R11 reset level", level, 0);
    chk(empty && !full, "R11 reset empty", empty, 1);
    chk({irq_trig, irq_empty, irq_ovr} == 3'b000, "R11 reset flags", {irq_trig, irq_empty, irq_ovr}, 0);
    chk(!rd_valid, "R11 reset rd_valid", rd_valid, 0);
  endtask

  task automatic t_empty_read();
    logic [7:0] d; logic v;
    pop(d, v);
    chk(!v, "R4 empty read rd_valid", v, 0);
    chk(level == 0, "R4 empty read level", level, 0);
  endtask

  task automatic t_empty_normal();
    logic [7:0] d; logic v;
    cfg_load(4'd3, 1'b0, 1'b0, 1'b0);
    ack();
    push(8'h5A);
    chk(!irq_empty, "R7 no flag on write into empty", irq_empty, 0);
    pop(d, v);
    chk(v && d == 8'h5A, "R2 single word read", d, 8'h5A);
    chk(irq_empty, "R7 flag on drain to empty", irq_empty, 1);
    ack();
    chk(!irq_empty, "R9 ack clears flag", irq_empty, 0);
  endtask

  task automatic t_trigger();
    logic [7:0] d; logic v;
    cfg_load(4'd2, 1'b0, 1'b0, 1'b0);
    ack();
    cfg_trig_lvl = 4'd0; cfg_trig_inv = 1'b1;
    push(8'd100);
    chk(!irq_trig, "R12 config ignored without cfg_we", irq_trig, 0);
    for (int i = 1; i < 16; i++) push(8'(100 + i));
    chk(level == 16 && !irq_trig, "R5 no flag at threshold 16", irq_trig, 0);
    push(8'd116);
    chk(irq_trig, "R5 flag above threshold 16", irq_trig, 1);
    ack();
    for (int i = 0; i < 17; i++) begin
      pop(d, v);
      chk(v && d == 8'(100 + i), "R2 read order", d, 100 + i);
    end
    chk(!irq_trig, "R5 no flag on downward crossing", irq_trig, 0);
    chk(irq_empty, "R7 flag after draining", irq_empty, 1);
  endtask

  task automatic t_inverted();
    logic [7:0] d; logic v;
    cfg_load(4'd1, 1'b1, 1'b1, 1'b0);
    ack();
    push(8'd1);
    chk(irq_empty, "R8 flag on write into empty", irq_empty, 1);
    for (int i = 2; i <= 10; i++) push(8'(i));
    chk(!irq_trig, "R6 no flag on upward crossing", irq_trig, 0);
    ack();
    pop(d, v); pop(d, v);
    chk(level == 8 && !irq_trig, "R6 no flag at threshold 8", irq_trig, 0);
    pop(d, v);
    chk(irq_trig, "R6 flag below threshold 8", irq_trig, 1);
    chk(!irq_empty, "R8 no flag on read", irq_empty, 0);
    cfg_load(4'd0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    ack();
  endtask

  task automatic t_full_clear();
    logic [7:0] d; logic v;
    cfg_load(4'd0, 1'b0, 1'b0, 1'b0);
    ack();
    for (int i = 0; i < 128; i++) push(8'(i));
    chk(level == 128 && full, "R1 level at 128", level, 128);
    chk(!irq_ovr, "R3 no overrun before full write", irq_ovr, 0);
    push(8'hEE);
    chk(irq_ovr, "R3 overrun flag", irq_ovr, 1);
    chk(level == 128, "R3 level unchanged", level, 128);
    pop(d, v);
    chk(v && d == 8'd0, "R3 head word unchanged", d, 0);
    chk(level == 127, "R2 level after read", level, 127);
    cfg_load(4'd0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk(level == 0 && empty, "R10 clear empties store", level, 0);
    push(8'h33);
    chk(level == 0, "R10 write ignored while clear", level, 0);
    cfg_load(4'd0, 1'b0, 1'b0, 1'b0);
    push(8'h44);
    pop(d, v);
    chk(v && d == 8'h44, "R10 normal after clear", d, 8'h44);
  endtask

  task automatic t_ack_race();
    cfg_load(4'd0, 1'b0, 1'b0, 1'b0);
    ack();
    chk(level == 0 && !irq_trig, "R9 flags cleared", irq_trig, 0);
    wr_en = 1'b1; wr_data = 8'h10; irq_ack = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; irq_ack = 1'b0;
    chk(irq_trig, "R9 event beats ack", irq_trig, 1);
    @(negedge clk);
    chk(irq_trig, "R9 flag sticky", irq_trig, 1);
  endtask

  task automatic t_sw_reset();
    cfg_load(4'd5, 1'b1, 1'b1, 1'b0);
    push(8'h1); push(8'h2); push(8'h3);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    chk(level == 0 && empty, "R11 sw reset empties", level, 0);
    chk({irq_trig, irq_empty, irq_ovr} == 3'b000, "R11 sw reset flags", {irq_trig, irq_empty, irq_ovr}, 0);
    push(8'h9);
    chk(irq_trig, "R11 threshold back to 0 normal", irq_trig, 1);
    chk(!irq_empty, "R11 empty invert cleared", irq_empty, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sw_rst = 1'b0; cfg_we = 1'b0; cfg_trig_lvl = '0;
    cfg_trig_inv = 1'b0; cfg_empty_inv = 1'b0; cfg_fifo_clr = 1'b0;
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_empty_read();
    t_empty_normal();
    t_trigger();
    t_inverted();
    t_full_clear();
    t_ack_race();
    t_sw_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule